// File: doc/BRIEF.md
# Translation Walk Request Queue

This block sits in front of a page-table walker and decides which translation request walks next. Requests carrying a tag, a virtual address and an access mode are pushed into an in-order queue. Only the request at the head of the queue is ever handed to the walker, and the walker sees a single request at a time through a valid/ready start handshake. When the walker reports that the walk is done, the queue returns a completion carrying the request tag and the walker's fault code, then drops the entry.

A requester can cancel queued or running requests by tag with a squash update. Squashed entries are not walked. When the controller reaches a restart point, it pops squashed heads and completes each with a dedicated squash fault. It pops no more than a configured number of them before it launches the head. If the walk already running is squashed, the completion goes out at once. The entry stays in place until the walker's count of outstanding memory operations reaches zero, so late memory responses never belong to a newer walk.

Top module: `walk_queue`

## Requirements
- R1: After reset the queue is empty: push_ready_o is 1, start_valid_o is 0 and cpl_valid_o is 0.
- R2: push_ready_o is 0 exactly while DEPTH entries are held. A push offered while push_ready_o is 0 is dropped and is never started or completed.
- R3: Requests are started in push order. start_valid_o rises only for the head, and it is 0 in the cycle after a start handshake. No new start is offered until the running request has completed or been released.
- R4: A walk_done_i pulse for a running, unsquashed request gives cpl_valid_o in the next cycle, with that request's tag and cpl_fault_o equal to walk_fault_i from the pulse cycle. The entry is then removed. A scan cycle always separates the done pulse from the next start offer, so the earliest new start_valid_o is two cycles after the pulse.
- R5: A squash_valid_i update marks every held entry whose tag equals squash_tag_i, including the running one, and the mark takes effect from the next cycle. An entry pushed in the same cycle as the update is not marked.
- R6: In a scan cycle with a marked head, the head is popped and completes one cycle later with cpl_fault_o all ones (the squash code). Each cycle pops one entry, and one scan round pops at most MAX_SQ entries. After that the head is launched even if it is marked.
- R7: When the running request is marked, it completes with the squash code in the cycle after the mark is first seen. It stays in the queue until inflight_i is 0, and walk_done_i pulses during that drain are ignored. The queue rescans after the release.
- R8: While start_valid_o is 1 and start_ready_i is 0, start_valid_o stays 1 and the start tag, address and mode do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | New request offered |
| push_ready_o | output | 1 | Queue has room |
| push_tag_i | input | TAG_W | Request tag |
| push_addr_i | input | ADDR_W | Virtual address to translate |
| push_mode_i | input | MODE_W | Access mode |
| squash_valid_i | input | 1 | Squash update strobe |
| squash_tag_i | input | TAG_W | Tag to squash |
| start_valid_o | output | 1 | Head request offered to the walker |
| start_ready_i | input | 1 | Walker accepts the start |
| start_tag_o | output | TAG_W | Tag of the offered request |
| start_addr_o | output | ADDR_W | Address of the offered request |
| start_mode_o | output | MODE_W | Mode of the offered request |
| walk_done_i | input | 1 | Running walk finished |
| walk_fault_i | input | FAULT_W | Fault code of the finished walk |
| inflight_i | input | INFL_W | Outstanding memory operations of the running walk |
| cpl_valid_o | output | 1 | Completion strobe |
| cpl_tag_o | output | TAG_W | Tag of the completed request |
| cpl_fault_o | output | FAULT_W | Fault code, all ones for a squash |

## Verification
The queue's order, its squash marks and its controller phase are all internal. A fault in any of them shows up at the ports within a few cycles. A wrong pointer or mark puts the wrong tag on start_tag_o or cpl_tag_o at the next offer or pop. A wrong phase or round counter moves start_valid_o or cpl_valid_o by at least one cycle. A wrong occupancy count moves push_ready_o at the next push. The reference model is compared against every output on every cycle, so these faults are caught at the first cycle in which they differ, not only at the end of a transaction.

// File: rtl/walk_queue_pkg.sv
package walk_queue_pkg;
  typedef enum logic [1:0] {
    PH_SCAN   = 2'd0,
    PH_LAUNCH = 2'd1,
    PH_WALK   = 2'd2,
    PH_DRAIN  = 2'd3
  } wq_phase_e;
endpackage

// File: rtl/walk_queue_store.sv
module walk_queue_store #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 16,
  parameter int MODE_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [MODE_W-1:0] push_mode_i,
  input  logic              pop_i,
  input  logic              mark_i,
  input  logic [TAG_W-1:0]  mark_tag_i,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [MODE_W-1:0] head_mode_o,
  output logic              head_sq_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [MODE_W-1:0] mode_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, sq_q;
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        sq_q[g]   <= 1'b0;
        tag_q[g]  <= '0;
        addr_q[g] <= '0;
        mode_q[g] <= '0;
      end else if (push_i && wr_q == PTR_W'(g)) begin
        vld_q[g]  <= 1'b1;
        sq_q[g]   <= 1'b0;
        tag_q[g]  <= push_tag_i;
        addr_q[g] <= push_addr_i;
        mode_q[g] <= push_mode_i;
      end else if (pop_i && rd_q == PTR_W'(g)) begin
        vld_q[g] <= 1'b0;
        sq_q[g]  <= 1'b0;
      end else if (mark_i && vld_q[g] && tag_q[g] == mark_tag_i) begin
        sq_q[g] <= 1'b1;
      end
    end
  end

  assign head_tag_o  = tag_q[rd_q];
  assign head_addr_o = addr_q[rd_q];
  assign head_mode_o = mode_q[rd_q];
  assign head_sq_o   = sq_q[rd_q];
  assign cnt_o       = cnt_q;
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/walk_queue_ctrl.sv
module walk_queue_ctrl
  import walk_queue_pkg::*;
#(
  parameter int MAX_SQ = 2,
  localparam int SC_W  = $clog2(MAX_SQ + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            empty_i,
  input  logic            head_sq_i,
  input  logic            start_ready_i,
  input  logic            walk_done_i,
  input  logic            drained_i,
  output wq_phase_e       phase_o,
  output logic [SC_W-1:0] sq_cnt_o,
  output logic            pop_o,
  output logic            start_valid_o,
  output logic            evt_o,
  output logic            evt_sq_o
);
  wq_phase_e       ph_q, ph_d;
  logic [SC_W-1:0] sc_q, sc_d;

  always_comb begin
    ph_d          = ph_q;
    pop_o         = 1'b0;
    evt_o         = 1'b0;
    evt_sq_o      = 1'b0;
    start_valid_o = 1'b0;
    unique case (ph_q)
      PH_SCAN: begin
        if (!empty_i) begin
          // bounded discard of squashed heads per round
          if (head_sq_i && sc_q < SC_W'(MAX_SQ)) begin
            pop_o    = 1'b1;
            evt_o    = 1'b1;
            evt_sq_o = 1'b1;
          end else begin
            ph_d = PH_LAUNCH;
          end
        end
      end
      PH_LAUNCH: begin
        start_valid_o = 1'b1;
        if (start_ready_i) ph_d = PH_WALK;
      end
      PH_WALK: begin
        if (head_sq_i) begin
          evt_o    = 1'b1;
          evt_sq_o = 1'b1;
          if (drained_i) begin
            pop_o = 1'b1;
            ph_d  = PH_SCAN;
          end else begin
            ph_d = PH_DRAIN;
          end
        end else if (walk_done_i) begin
          evt_o = 1'b1;
          pop_o = 1'b1;
          ph_d  = PH_SCAN;
        end
      end
      PH_DRAIN: begin
        if (drained_i) begin
          pop_o = 1'b1;
          ph_d  = PH_SCAN;
        end
      end
      default: ph_d = PH_SCAN;
    endcase
    sc_d = (ph_q == PH_SCAN && !empty_i) ? sc_q + SC_W'(pop_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_SCAN;
      sc_q <= '0;
    end else begin
      ph_q <= ph_d;
      sc_q <= sc_d;
    end
  end

  assign phase_o  = ph_q;
  assign sq_cnt_o = sc_q;
endmodule

// File: rtl/walk_queue.sv
module walk_queue
  import walk_queue_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_SQ  = 2,
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 16,
  parameter int MODE_W  = 2,
  parameter int INFL_W  = 3,
  parameter int FAULT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_valid_i,
  output logic               push_ready_o,
  input  logic [TAG_W-1:0]   push_tag_i,
  input  logic [ADDR_W-1:0]  push_addr_i,
  input  logic [MODE_W-1:0]  push_mode_i,
  input  logic               squash_valid_i,
  input  logic [TAG_W-1:0]   squash_tag_i,
  output logic               start_valid_o,
  input  logic               start_ready_i,
  output logic [TAG_W-1:0]   start_tag_o,
  output logic [ADDR_W-1:0]  start_addr_o,
  output logic [MODE_W-1:0]  start_mode_o,
  input  logic               walk_done_i,
  input  logic [FAULT_W-1:0] walk_fault_i,
  input  logic [INFL_W-1:0]  inflight_i,
  output logic               cpl_valid_o,
  output logic [TAG_W-1:0]   cpl_tag_o,
  output logic [FAULT_W-1:0] cpl_fault_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SC_W  = $clog2(MAX_SQ + 1);
  localparam logic [FAULT_W-1:0] SQ_FAULT = '1;

  logic              push, pop, full, head_sq, evt, evt_sq;
  logic [CNT_W-1:0]  cnt;
  logic [SC_W-1:0]   sq_cnt;
  logic [TAG_W-1:0]  head_tag;
  wq_phase_e         st;

  assign push_ready_o = !full;
  assign push         = push_valid_i && !full;

  walk_queue_store #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_tag_i  (push_tag_i),
    .push_addr_i (push_addr_i),
    .push_mode_i (push_mode_i),
    .pop_i       (pop),
    .mark_i      (squash_valid_i),
    .mark_tag_i  (squash_tag_i),
    .head_tag_o  (head_tag),
    .head_addr_o (start_addr_o),
    .head_mode_o (start_mode_o),
    .head_sq_o   (head_sq),
    .cnt_o       (cnt),
    .full_o      (full)
  );

  walk_queue_ctrl #(.MAX_SQ(MAX_SQ)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .empty_i       (cnt == '0),
    .head_sq_i     (head_sq),
    .start_ready_i (start_ready_i),
    .walk_done_i   (walk_done_i),
    .drained_i     (inflight_i == '0),
    .phase_o       (st),
    .sq_cnt_o      (sq_cnt),
    .pop_o         (pop),
    .start_valid_o (start_valid_o),
    .evt_o         (evt),
    .evt_sq_o      (evt_sq)
  );

  assign start_tag_o = head_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_valid_o <= 1'b0;
      cpl_tag_o   <= '0;
      cpl_fault_o <= '0;
    end else begin
      cpl_valid_o <= evt;
      if (evt) begin
        cpl_tag_o   <= head_tag;
        cpl_fault_o <= evt_sq ? SQ_FAULT : walk_fault_i;
      end
    end
  end
endmodule

// File: rtl/walk_queue_chk.sv
module walk_queue_chk
  import walk_queue_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_SQ  = 2,
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 16,
  parameter int MODE_W  = 2,
  parameter int FAULT_W = 3,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SC_W   = $clog2(MAX_SQ + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               push_valid_i,
  input logic               push_ready_o,
  input logic               start_valid_o,
  input logic               start_ready_i,
  input logic [TAG_W-1:0]   start_tag_o,
  input logic [ADDR_W-1:0]  start_addr_o,
  input logic [MODE_W-1:0]  start_mode_o,
  input logic               walk_done_i,
  input logic [FAULT_W-1:0] walk_fault_i,
  input logic               cpl_valid_o,
  input logic [FAULT_W-1:0] cpl_fault_o,
  input wq_phase_e          st_i,
  input logic               head_sq_i,
  input logic               pop_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [SC_W-1:0]    sq_cnt_i
);
  assert_push_counts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_i && push_ready_o && !pop_i |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  assert_single_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o && start_ready_i |=> !start_valid_o);

  assert_done_cpl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == PH_WALK && !head_sq_i && walk_done_i
    |=> cpl_valid_o && cpl_fault_o == $past(walk_fault_i));

  assert_round_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == PH_SCAN |-> sq_cnt_i <= SC_W'(MAX_SQ));

  assert_drain_ignores_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == PH_DRAIN && walk_done_i |=> !cpl_valid_o);

  assert_start_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o && !start_ready_i
    |=> start_valid_o && $stable(start_tag_o) && $stable(start_addr_o) && $stable(start_mode_o));
endmodule

bind walk_queue walk_queue_chk #(
  .DEPTH(DEPTH), .MAX_SQ(MAX_SQ), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
  .MODE_W(MODE_W), .FAULT_W(FAULT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .push_valid_i  (push_valid_i),
  .push_ready_o  (push_ready_o),
  .start_valid_o (start_valid_o),
  .start_ready_i (start_ready_i),
  .start_tag_o   (start_tag_o),
  .start_addr_o  (start_addr_o),
  .start_mode_o  (start_mode_o),
  .walk_done_i   (walk_done_i),
  .walk_fault_i  (walk_fault_i),
  .cpl_valid_o   (cpl_valid_o),
  .cpl_fault_o   (cpl_fault_o),
  .st_i          (st),
  .head_sq_i     (head_sq),
  .pop_i         (pop),
  .cnt_i         (cnt),
  .sq_cnt_i      (sq_cnt)
);

// File: tb/test_walk_queue.sv
module test_walk_queue;
  localparam int DEPTH = 4;
  localparam int MAXSQ = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push_v = 0, sq_v = 0, st_rdy = 1, done = 0;
  logic [3:0]  push_tag = 0, sq_tag = 0;
  logic [15:0] push_addr = 0;
  logic [1:0]  push_mode = 0;
  logic [2:0]  fault = 0, infl = 0;
  logic        push_ready_o, start_valid_o, cpl_valid_o;
  logic [3:0]  start_tag_o, cpl_tag_o;
  logic [15:0] start_addr_o;
  logic [1:0]  start_mode_o;
  logic [2:0]  cpl_fault_o;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  walk_queue i_walk_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_v), .push_ready_o(push_ready_o),
    .push_tag_i(push_tag), .push_addr_i(push_addr), .push_mode_i(push_mode),
    .squash_valid_i(sq_v), .squash_tag_i(sq_tag),
    .start_valid_o(start_valid_o), .start_ready_i(st_rdy),
    .start_tag_o(start_tag_o), .start_addr_o(start_addr_o), .start_mode_o(start_mode_o),
    .walk_done_i(done), .walk_fault_i(fault), .inflight_i(infl),
    .cpl_valid_o(cpl_valid_o), .cpl_tag_o(cpl_tag_o), .cpl_fault_o(cpl_fault_o)
  );

  // reference model
  typedef struct {
    logic [3:0]  tag;
    logic [15:0] addr;
    logic [1:0]  mode;
    bit          sq;
  } ent_t;
  ent_t  q[$];
  int    ph;          // 0 scan, 1 offer, 2 walking, 3 draining
  int    scnt;
  bit    m_cv;
  logic [3:0] m_ctag;
  logic [2:0] m_cfault;
  string m_cause = "R4";
  bit    prev_sv = 0;

  always @(posedge clk or negedge rst_n) begin
    int  sz;
    bit  pop, ev, evsq, rdy;
    ent_t e;
    if (!rst_n) begin
      q.delete(); ph = 0; scnt = 0; m_cv = 0;
    end else begin
      sz = q.size(); pop = 0; ev = 0; evsq = 0;
      case (ph)
        0: if (sz > 0) begin
             if (q[0].sq && scnt < MAXSQ) begin
               pop = 1; ev = 1; evsq = 1; scnt++; m_cause = "R5,R6";
             end else ph = 1;
           end
        1: if (st_rdy) ph = 2;
        2: if (q[0].sq) begin
             ev = 1; evsq = 1; m_cause = "R5,R7";
             if (infl == 0) begin pop = 1; ph = 0; end else ph = 3;
           end else if (done) begin
             ev = 1; pop = 1; ph = 0; m_cause = "R4";
           end
        default: if (infl == 0) begin pop = 1; ph = 0; end
      endcase
      if (ph != 0 || q.size() == 0 || (pop && sz == 1)) scnt = (ph == 0 && pop && sz > 1) ? scnt : (ph == 0 ? scnt : 0);
      if (ph != 0) scnt = 0;
      m_cv = ev;
      if (ev) begin
        m_ctag   = q[0].tag;
        m_cfault = evsq ? 3'b111 : fault;
      end
      if (sq_v) foreach (q[i]) if (q[i].tag == sq_tag) q[i].sq = 1;
      rdy = (sz < DEPTH);
      if (pop) void'(q.pop_front());
      if (push_v && rdy) begin
        e.tag = push_tag; e.addr = push_addr; e.mode = push_mode; e.sq = 0;
        q.push_back(e);
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison; all outputs come from registers
  always @(negedge clk) begin
    bit esv;
    if (rst_n && !ended) begin
      chk(push_ready_o === (q.size() < DEPTH), "R2", push_ready_o, q.size() < DEPTH);
      esv = (ph == 1);
      chk(start_valid_o === esv, "R3", start_valid_o, esv);
      if (esv && start_valid_o) begin
        chk(start_tag_o === q[0].tag, prev_sv ? "R8" : "R3", start_tag_o, q[0].tag);
        chk(start_addr_o === q[0].addr, prev_sv ? "R8" : "R3", start_addr_o, q[0].addr);
        chk(start_mode_o === q[0].mode, prev_sv ? "R8" : "R3", start_mode_o, q[0].mode);
      end
      prev_sv = esv && !st_rdy;
      chk(cpl_valid_o === m_cv, m_cause, cpl_valid_o, m_cv);
      if (m_cv && cpl_valid_o) begin
        chk(cpl_tag_o === m_ctag, m_cause, cpl_tag_o, m_ctag);
        chk(cpl_fault_o === m_cfault, m_cause, cpl_fault_o, m_cfault);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [3:0] t);
    push_v = 1; push_tag = t; push_addr = 16'h1000 + 16'(t) * 16'h10; push_mode = t[1:0];
    cyc();
    push_v = 0;
  endtask

  task automatic squash(logic [3:0] t);
    sq_v = 1; sq_tag = t;
    cyc();
    sq_v = 0;
  endtask

  task automatic walk_done(logic [2:0] f);
    done = 1; fault = f;
    cyc();
    done = 0;
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk(push_ready_o === 1'b1, "R1", push_ready_o, 1);
    chk(start_valid_o === 1'b0, "R1", start_valid_o, 0);
    chk(cpl_valid_o === 1'b0, "R1", cpl_valid_o, 0);
    rst_n = 1;
    cyc();

    // R8: offer held while walker stalls
    st_rdy = 0;
    push(4'd1);
    cyc(3);
    st_rdy = 1;
    cyc();
    // R2: fill while walking, two extra pushes dropped
    push(4'd2); push(4'd3); push(4'd4); push(4'd5); push(4'd6);
    chk(push_ready_o === 1'b0, "R2", push_ready_o, 0);
    // R4: walker fault passed through
    walk_done(3'd5);
    cyc(3);
    // R6: queued entry squashed, popped at restart
    squash(4'd3);
    push(4'd7);
    walk_done(3'd0);
    cyc(4);
    // R6: three marked heads, only MAX_SQ popped in one round
    push(4'd8); push(4'd9);
    squash(4'd7); squash(4'd8); squash(4'd9);
    walk_done(3'd1);
    cyc(8);
    // R7: running walk squashed with memory operations outstanding
    infl = 3'd2;
    push(4'd10);
    cyc(4);
    squash(4'd10);
    cyc();
    walk_done(3'd3);
    cyc(2);
    infl = 3'd0;
    cyc(3);
    // R5: one update marks several entries, same-cycle push unmarked
    st_rdy = 0;
    push(4'd11);
    cyc(2);
    push(4'd11);
    push_v = 1; push_tag = 4'd11; push_addr = 16'h2222; push_mode = 2'd2;
    sq_v = 1; sq_tag = 4'd11;
    cyc();
    push_v = 0; sq_v = 0;
    cyc(2);
    st_rdy = 1;
    cyc(8);
    walk_done(3'd2);
    cyc(4);
    summary();
  end
endmodule